// File: doc/BRIEF.md
# Sync Change Interrupt Controller

This block watches two flags per input channel, one for sync activity and one for sync polarity, and reports any change in them to software. Each channel owns one sticky status bit. The bit sets when the channel's flag pair differs from the pair sampled on the previous clock. Software reads the status bits through a small register port and clears a bit by writing a one to it.

A separate mask register selects which status bits may raise the single active-high interrupt line. A mask bit of one blocks its channel. The mask comes out of reset as all ones, so nothing interrupts until software opens the mask. The interrupt line is the registered OR of every status bit whose mask bit is zero.

The register port is flat: an address, write data, a write strobe and combinational read data. Status sits at address 0x00 and the mask at address 0x01. Any other address reads as zero and ignores writes.

Top module: `sync_chg_irq`

## Requirements
- R1: After reset, status (address 0x00) reads 0x00, the mask (address 0x01) reads 0x0F, and `irq` is 0.
- R2: When `act_i[n]` at a rising clock edge differs from its value at the previous edge, status bit n reads 1 after that edge.
- R3: When `pol_i[n]` at a rising clock edge differs from its value at the previous edge, status bit n reads 1 after that edge.
- R4: A set status bit stays set while its flags are stable, until software clears it.
- R5: A write to address 0x00 clears each status bit whose write-data bit is 1. Bits written 0 keep their value. Writing 0xFF clears all of them.
- R6: If a change is detected on a channel in the same cycle as a clear of that channel's bit, the bit ends up set.
- R7: A write to address 0x01 loads the low 4 bits of the mask, where bit n = 1 blocks channel n. `irq` equals the OR of (status AND NOT mask) as it stood before the previous rising edge, so it follows status and mask with one clock of delay.
- R8: Read-data bits 7..4 are always 0. Addresses other than 0x00 and 0x01 read 0x00, and writes to them change neither status nor mask.
- R9: A change on one channel sets only that channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_i | input | 4 | Activity flag per channel |
| pol_i | input | 4 | Polarity flag per channel |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one write per cycle in which it is high |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, active high, registered |

## Verification
A stale previous-flag register shows up at the status address on the cycle after the missed or false change. A corrupted status or mask bit shows up on `irq_o` one clock later. Because status and mask can be read at any time, every such fault becomes visible on the ports within two clocks. The bench therefore compares `irq_o` and the read data for the current address against a behavioural model on every clock. It also drives directed cases for simultaneous set and clear, writes to unmapped addresses, and partial masks.

// File: rtl/sci_pkg.sv
package sci_pkg;
   // flag pair observed on one channel
   typedef struct packed {
      logic act;
      logic pol;
   } sci_flag_t;

   localparam int unsigned SCI_FLAG_W = $bits(sci_flag_t);
endpackage

// File: rtl/sci_chan_watch.sv
// Holds the last sampled flag pair of one channel and flags a difference.
module sci_chan_watch
   import sci_pkg::*;
#(
   parameter sci_flag_t RST_FLAGS = '0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  sci_flag_t flags_i,
   output logic      chg_o
);
   sci_flag_t prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_FLAGS;
      else        prev_q <= flags_i;
   end

   assign chg_o = (flags_i != prev_q);
endmodule

// File: rtl/sci_status_bank.sv
// Sticky status bits: clear by request, set wins over clear.
module sci_status_bank #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] status_o
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (set_i[g])   bit_q <= 1'b1;
         else if (clr_i[g])   bit_q <= 1'b0;
      end
      assign status_o[g] = bit_q;
   end
endmodule

// File: rtl/sci_irq_gen.sv
// Mask register and interrupt combine; IRQ_REG picks registered or direct output.
module sci_irq_gen #(
   parameter int unsigned NUM_CH   = 4,
   parameter bit          IRQ_REG  = 1'b1,
   parameter logic [NUM_CH-1:0] MASK_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we_i,
   input  logic [NUM_CH-1:0] mask_d_i,
   input  logic [NUM_CH-1:0] status_i,
   output logic [NUM_CH-1:0] mask_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] mask_q;
   logic              any_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= MASK_RST;
      else if (mask_we_i) mask_q <= mask_d_i;
   end

   assign any_open = |(status_i & ~mask_q);
   assign mask_o   = mask_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_open;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = any_open;
   end
endmodule

// File: rtl/sync_chg_irq.sv
module sync_chg_irq
   import sci_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b1,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] act_i,
   input  logic [NUM_CH-1:0] pol_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_en_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam logic [NUM_CH-1:0] MASK_ALL = '1;

   initial begin
      if (NUM_CH < 1 || NUM_CH > DATA_W)
         $fatal(1, "sync_chg_irq: NUM_CH must lie in 1..DATA_W");
      if (STAT_ADDR == MASK_ADDR)
         $fatal(1, "sync_chg_irq: status and mask addresses collide");
   end

   logic [NUM_CH-1:0] chg_vec;
   logic [NUM_CH-1:0] status_vec;
   logic [NUM_CH-1:0] mask_vec;
   logic [NUM_CH-1:0] clr_vec;
   logic              stat_we;
   logic              mask_we;

   // per-channel change detectors
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sci_flag_t flags;
      assign flags.act = act_i[c];
      assign flags.pol = pol_i[c];
      sci_chan_watch #(.RST_FLAGS('0)) u_watch (
         .clk     (clk),
         .rst_n   (rst_n),
         .flags_i (flags),
         .chg_o   (chg_vec[c])
      );
   end

   assign stat_we = wr_en_i && (addr_i == STAT_ADDR);
   assign mask_we = wr_en_i && (addr_i == MASK_ADDR);
   assign clr_vec = stat_we ? wdata_i[NUM_CH-1:0] : '0;

   if (NUM_CH < DATA_W) begin : g_wd_unused
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_CH];
   end

   sci_status_bank #(.NUM_CH(NUM_CH)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (chg_vec),
      .clr_i    (clr_vec),
      .status_o (status_vec)
   );

   sci_irq_gen #(
      .NUM_CH   (NUM_CH),
      .IRQ_REG  (IRQ_REG),
      .MASK_RST (MASK_ALL)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we_i (mask_we),
      .mask_d_i  (wdata_i[NUM_CH-1:0]),
      .status_i  (status_vec),
      .mask_o    (mask_vec),
      .irq_o     (irq_o)
   );

   // read mux: unused bits and unmapped addresses give zero
   always_comb begin
      rdata_o = '0;
      if (addr_i == STAT_ADDR)      rdata_o[NUM_CH-1:0] = status_vec;
      else if (addr_i == MASK_ADDR) rdata_o[NUM_CH-1:0] = mask_vec;
   end
endmodule

// File: rtl/sci_irq_chk.sv
module sci_irq_chk #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b1,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 'h1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [NUM_CH-1:0] chg_vec,
   input logic [NUM_CH-1:0] status_vec,
   input logic [NUM_CH-1:0] mask_vec
);
   localparam logic [NUM_CH-1:0] ONES = '1;

   // R1
   mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_vec == ONES && status_vec == '0));

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && addr_i == STAT_ADDR) |=>
      ((status_vec & $past(status_vec)) == $past(status_vec)));

   // R5
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == STAT_ADDR) |=>
      ((status_vec & $past(wdata_i[NUM_CH-1:0]) & ~$past(chg_vec)) == '0));

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_vec != '0) |=> ((status_vec & $past(chg_vec)) == $past(chg_vec)));

   // R8
   rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((rdata_o >> NUM_CH) == '0));

   // R8
   stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i != STAT_ADDR && addr_i != MASK_ADDR) |=>
      $stable(mask_vec));

   if (IRQ_REG) begin : g_reg_chk
      // R7
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_o == $past(|(status_vec & ~mask_vec))));
   end
endmodule

bind sync_chg_irq sci_irq_chk #(
   .NUM_CH    (NUM_CH),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .IRQ_REG   (IRQ_REG),
   .STAT_ADDR (STAT_ADDR),
   .MASK_ADDR (MASK_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .wr_en_i    (wr_en_i),
   .rdata_o    (rdata_o),
   .irq_o      (irq_o),
   .chg_vec    (chg_vec),
   .status_vec (status_vec),
   .mask_vec   (mask_vec)
);

// File: tb/tb_sync_chg_irq.sv
module tb_sync_chg_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] act_i = '0;
   logic [3:0] pol_i = '0;
   logic [7:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic       wr_en_i = 1'b0;
   logic [7:0] rdata_o;
   logic       irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sync_chg_irq dut (
      .clk(clk), .rst_n(rst_n), .act_i(act_i), .pol_i(pol_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .wr_en_i(wr_en_i),
      .rdata_o(rdata_o), .irq_o(irq_o)
   );

   // behavioural reference model
   int m_stat, m_mask, m_irq, m_pa, m_pp;

   function automatic int model_read(int a);
      if (a == 0) return m_stat;
      if (a == 1) return m_mask;
      return 0;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      int ch;
      if (!rst_n) begin
         m_stat = 0; m_mask = 'hF; m_irq = 0; m_pa = 0; m_pp = 0;
      end else begin
         ch = (int'(act_i) ^ m_pa) | (int'(pol_i) ^ m_pp);
         m_irq = ((m_stat & ~m_mask & 'hF) != 0) ? 1 : 0;
         if (wr_en_i && addr_i == 0) m_stat = m_stat & ~int'(wdata_i[3:0]);
         m_stat = m_stat | ch;
         if (wr_en_i && addr_i == 1) m_mask = int'(wdata_i[3:0]);
         m_pa = int'(act_i); m_pp = int'(pol_i);
      end
      #3;
      if (rst_n && !done) begin
         check("R7 model irq", int'(irq_o), m_irq);
         check("R8 model rdata", int'(rdata_o), model_read(int'(addr_i)));
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      addr_i = 8'(a); wdata_i = 8'(d); wr_en_i = 1'b1;
      tick(1);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(int a, int exp, string req);
      addr_i = 8'(a);
      #1;
      check(req, int'(rdata_o), exp);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 20000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      summary();
      $finish;
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(2);
      rd(0, 'h00, "R1 status");
      rd(1, 'h0F, "R1 mask");
      check("R1 irq", int'(irq_o), 0);

      act_i = 4'b0001; tick(1);
      rd(0, 'h01, "R2 activity change");
      check("R7 masked irq", int'(irq_o), 0);

      pol_i = 4'b0100; tick(1);
      rd(0, 'h05, "R3 polarity change");
      rd(0, 'h05, "R9 only changed channels");

      tick(3);
      rd(0, 'h05, "R4 sticky");

      wr(1, 'h00); tick(1);
      check("R7 unmasked irq", int'(irq_o), 1);

      wr(0, 'h01); rd(0, 'h04, "R5 clear one");
      wr(0, 'h00); rd(0, 'h04, "R5 zero write");

      pol_i = 4'b0110; wr(0, 'h02);
      rd(0, 'h06, "R6 set wins");

      wr(0, 'hFF); rd(0, 'h00, "R5 clear all");
      tick(1);
      check("R7 irq drops", int'(irq_o), 0);

      wr(5, 'hFF);
      rd(0, 'h00, "R8 stray write status");
      rd(1, 'h00, "R8 stray write mask");
      rd(5, 'h00, "R8 unmapped read");

      wr(1, 'h0B);
      act_i = 4'b0000; tick(2);
      check("R7 blocked channel", int'(irq_o), 0);
      rd(0, 'h01, "R2 ch0 back");
      act_i = 4'b0100; tick(2);
      rd(0, 'h05, "R9 ch2 only");
      check("R7 open channel", int'(irq_o), 1);

      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 3) == 0) act_i = act_i ^ 4'($urandom_range(0, 15));
         if ($urandom_range(0, 3) == 0) pol_i = pol_i ^ 4'($urandom_range(0, 15));
         addr_i  = 8'($urandom_range(0, 2));
         wdata_i = 8'($urandom_range(0, 255));
         wr_en_i = ($urandom_range(0, 2) == 0);
         tick(1);
      end
      wr_en_i = 1'b0;
      tick(2);
      done = 1;
      summary();
      $finish;
   end
endmodule